// File: doc/BRIEF.md
# Presettable Cascadable Synchronous Counter

This block is a small binary up-counter, four bits wide by default, that can be preset from a parallel input and cleared to zero by an active-low clear. Counting needs two enables that are both high. The first, `cnt_en`, only gates counting. The second, `carry_in`, gates counting and also gates the terminal-count flag `carry_out`. A parallel load takes priority over both enables. Clear takes priority over everything.

A wider counter is built by chaining stages. Every stage shares the clock, clear and load. The lowest stage has `carry_in` tied high. Each higher stage takes the `carry_out` of the stage below as its `carry_in`. A higher stage therefore advances exactly once for each full cycle of the stages beneath it, and the carry does not ripple through clocked logic.

A compile-time parameter selects how clear acts. In asynchronous mode it forces zero at once, with no clock edge. In synchronous mode it takes effect only at the next rising edge.

Top module: `cascade_counter`

## Requirements
- R1: When `load_n` is low at a rising edge and `clr_n` is high, `q` takes `din` whatever the levels of `cnt_en` and `carry_in`.
- R2: When `load_n`, `cnt_en` and `carry_in` are all high at a rising edge and `clr_n` is high, `q` increases by one.
- R3: When `load_n` is high and either `cnt_en` or `carry_in` is low at a rising edge, `q` keeps its value.
- R4: Counting from all ones (1111 at the default width) gives all zeros at the next counting edge.
- R5: `carry_out` is high exactly when `carry_in` is high and `q` is all ones. `cnt_en` has no effect on it.
- R6: While `clr_n` is low, `q` is zero after the next rising edge and `carry_out` is low, whatever `load_n`, `cnt_en` and `carry_in` are.
- R7: With `ASYNC_CLR = 1`, a falling `clr_n` forces `q` to zero at once, before any clock edge.
- R8: With `ASYNC_CLR = 0`, a falling `clr_n` leaves `q` unchanged until the next rising edge, and `q` becomes zero at that edge.
- R9: Stages chained through `carry_out` into the next stage's `carry_in` count as one binary counter of the combined width, with the correct wrap from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; loading and counting happen on its rising edge |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous according to `ASYNC_CLR` |
| load_n | input | 1 | Active-low parallel load |
| cnt_en | input | 1 | Count enable that gates counting only |
| carry_in | input | 1 | Count enable that also gates `carry_out` |
| din | input | WIDTH | Preset value |
| q | output | WIDTH | Counter state |
| carry_out | output | 1 | Terminal-count flag, used to enable the next stage |

## Verification
The hardest case to reach is the top of a chained counter. There, every lower stage sits at all ones at the same moment, so the carry crosses several stages in a single edge. Counting from zero would take thousands of cycles to get there. The bench instead presets each stage of a three-stage chain separately to a value just below the top and counts through the wrap. A full sweep from zero covers the lower-stage carries.

The difference between the two clear modes only shows between edges. The bench therefore lowers clear shortly after a rising edge and samples before the next edge. It does this once on the asynchronous instance and once on the synchronous chain.

// File: rtl/ccnt_pkg.sv
package ccnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2
  } ccnt_op_e;
endpackage

// File: rtl/ccnt_ctrl.sv
module ccnt_ctrl
  import ccnt_pkg::*;
(
  input  logic     load_n,
  input  logic     cnt_en,
  input  logic     carry_in,
  output ccnt_op_e op
);
  // load outranks both enables; counting needs both enables
  logic both_en;
  assign both_en = cnt_en & carry_in;

  always_comb begin
    if (!load_n)      op = OP_LOAD;
    else if (both_en) op = OP_INC;
    else              op = OP_HOLD;
  end
endmodule

// File: rtl/ccnt_state.sv
module ccnt_state
  import ccnt_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  ccnt_op_e         op,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  function automatic logic [WIDTH-1:0] step_up(input logic [WIDTH-1:0] v);
    return v + {{(WIDTH-1){1'b0}}, 1'b1};
  endfunction

  logic             do_load;
  logic             do_inc;
  logic [WIDTH-1:0] nxt;

  assign do_load = (op == OP_LOAD);
  assign do_inc  = (op == OP_INC);

  always_comb begin
    nxt = q;
    if (do_load)     nxt = din;
    else if (do_inc) nxt = step_up(q);
  end

  generate
    if (ASYNC_CLR) begin : g_async_clr
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= nxt;
      end
    end else begin : g_sync_clr
      always_ff @(posedge clk) begin
        if (!clr_n) q <= '0;
        else        q <= nxt;
      end
    end
  endgenerate

  AST_CLEAR_ZERO: assert property (@(posedge clk) !clr_n |=> (q == '0)); // R6
  AST_LOAD_TAKES_DIN: assert property (@(posedge clk) disable iff (!clr_n)
    do_load |=> (q == $past(din))); // R1
  AST_INC_BY_ONE: assert property (@(posedge clk) disable iff (!clr_n)
    do_inc |=> (q == step_up($past(q)))); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!clr_n)
    (op == OP_HOLD) |=> $stable(q)); // R3
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!clr_n)
    (do_inc && q == ALL_ONES) |=> (q == '0)); // R4
endmodule

// File: rtl/ccnt_tc.sv
module ccnt_tc #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             carry_in,
  output logic             carry_out
);
  logic at_top;
  assign at_top    = &q;
  assign carry_out = carry_in & at_top;
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
  import ccnt_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             cnt_en,
  input  logic             carry_in,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry_out
);
  ccnt_op_e op;

  ccnt_ctrl u_ctrl (
    .load_n   (load_n),
    .cnt_en   (cnt_en),
    .carry_in (carry_in),
    .op       (op)
  );

  ccnt_state #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_state (
    .clk   (clk),
    .clr_n (clr_n),
    .op    (op),
    .din   (din),
    .q     (q)
  );

  ccnt_tc #(.WIDTH(WIDTH)) u_tc (
    .q         (q),
    .carry_in  (carry_in),
    .carry_out (carry_out)
  );

  AST_TC_NEEDS_TOP: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out |-> (carry_in && (&q))); // R5
  AST_TOP_GIVES_TC: assert property (@(posedge clk) disable iff (!clr_n)
    (carry_in && (&q)) |-> carry_out); // R5
  AST_TC_LOW_CLEARED: assert property (@(posedge clk)
    (!clr_n && !$rose(clr_n) && $past(!clr_n)) |-> !carry_out); // R6
endmodule

// File: tb/tb_cascade_counter.sv
`timescale 1ns/1ps
module tb_cascade_counter;
  localparam int W = 4;
  localparam int NST = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // single asynchronous-clear instance
  logic         clr_n, load_n, cnt_en, carry_in;
  logic [W-1:0] din, q;
  logic         carry_out;

  cascade_counter #(.WIDTH(W), .ASYNC_CLR(1'b1)) dut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
    .carry_in(carry_in), .din(din), .q(q), .carry_out(carry_out)
  );

  // three-stage synchronous-clear chain
  logic         s_clr_n, s_load_n, s_en0;
  logic [W-1:0] s_din [NST];
  logic [W-1:0] s_q   [NST];
  logic         s_co  [NST];
  logic         s_ci  [NST];

  for (genvar i = 0; i < NST; i++) begin : g_chain
    if (i == 0) begin : g_first
      assign s_ci[i] = s_en0;
    end else begin : g_next
      assign s_ci[i] = s_co[i-1];
    end
    cascade_counter #(.WIDTH(W), .ASYNC_CLR(1'b0)) u_stage (
      .clk(clk), .clr_n(s_clr_n), .load_n(s_load_n), .cnt_en(1'b1),
      .carry_in(s_ci[i]), .din(s_din[i]), .q(s_q[i]), .carry_out(s_co[i])
    );
  end

  function automatic int chain_val();
    return int'({s_q[2], s_q[1], s_q[0]});
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edge_then_sample();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(1_000_000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    int exp_q;
    int exp_c;
    clr_n = 1'b0; load_n = 1'b1; cnt_en = 1'b1; carry_in = 1'b1; din = '0;
    s_clr_n = 1'b0; s_load_n = 1'b1; s_en0 = 1'b1;
    for (int i = 0; i < NST; i++) s_din[i] = '0;
    edge_then_sample();
    edge_then_sample();
    // R6: cleared state, terminal flag low despite enables high
    check("R6 q", int'(q), 0);
    check("R6 carry_out", int'(carry_out), 0);
    check("R6 chain", chain_val(), 0);
    @(negedge clk);
    clr_n = 1'b1; s_clr_n = 1'b1; s_en0 = 1'b0;

    // sweep every preset value and every enable pair
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      load_n = 1'b0; din = W'(v); cnt_en = v[0]; carry_in = v[1];
      edge_then_sample();
      exp_q = v;
      check("R1 load", int'(q), exp_q);
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        load_n = 1'b1; din = W'(15 - v); cnt_en = c[0]; carry_in = c[1];
        edge_then_sample();
        if (c == 3) begin
          exp_q = (exp_q + 1) % 16;
          check((v == 15) ? "R4 wrap" : "R2 count", int'(q), exp_q);
        end else begin
          check("R3 hold", int'(q), exp_q);
        end
        check("R5 carry_out", int'(carry_out), (c[1] && exp_q == 15) ? 1 : 0);
      end
    end

    // R5: cnt_en low with carry_in high at top still flags
    @(negedge clk);
    load_n = 1'b0; din = 4'hF; cnt_en = 1'b0; carry_in = 1'b1;
    edge_then_sample();
    @(negedge clk);
    load_n = 1'b1;
    #1 check("R5 en ignored", int'(carry_out), 1);

    // R7: asynchronous clear between edges
    @(negedge clk);
    load_n = 1'b0; din = 4'd9; cnt_en = 1'b1; carry_in = 1'b1;
    edge_then_sample();
    @(negedge clk);
    load_n = 1'b1;
    @(posedge clk);
    #2 clr_n = 1'b0;
    #1 check("R7 immediate clear", int'(q), 0);
    edge_then_sample();
    check("R6 held clear", int'(q), 0);
    @(negedge clk);
    clr_n = 1'b1;

    // R9: chain counts from zero through several lower-stage carries
    @(negedge clk);
    s_load_n = 1'b0;
    edge_then_sample();
    check("R9 chain load", chain_val(), 0);
    @(negedge clk);
    s_load_n = 1'b1; s_en0 = 1'b1;
    exp_c = 0;
    for (int n = 0; n < 300; n++) begin
      edge_then_sample();
      exp_c = (exp_c + 1) % 4096;
      check("R9 chain count", chain_val(), exp_c);
    end

    // R9: preset near the top and cross the full-width wrap
    @(negedge clk);
    s_load_n = 1'b0; s_din[0] = 4'hD; s_din[1] = 4'hF; s_din[2] = 4'hF;
    edge_then_sample();
    check("R1 chain preset", chain_val(), 12'hFFD);
    @(negedge clk);
    s_load_n = 1'b1;
    exp_c = 12'hFFD;
    for (int n = 0; n < 4; n++) begin
      edge_then_sample();
      exp_c = (exp_c + 1) % 4096;
      check("R9 chain wrap", chain_val(), exp_c);
    end

    // R8: synchronous clear waits for the edge
    @(negedge clk);
    s_en0 = 1'b0;
    @(posedge clk);
    #2 s_clr_n = 1'b0;
    #1 check("R8 no early clear", chain_val(), exp_c);
    edge_then_sample();
    check("R8 clear at edge", chain_val(), 0);
    @(negedge clk);
    s_clr_n = 1'b1;

    done = 1'b1;
    finish_run();
  end
endmodule